// File: doc/BRIEF.md
# Posted-Pending Interrupt Controller

This block collects single-cycle event pulses from a set of hardware sources, such as timers and I/O pins. Each pulse is held in a per-source posted latch. The latch keeps its value whether or not the source is masked at that moment. A per-source enable register qualifies the posted bits into pending bits. A fixed-priority encoder then picks one pending source and forms its vector. The CPU sees one request line, gated by its global interrupt enable flag, together with that vector.

Software writes the enable register and clears posted bits through two plain write strobes. The CPU pulses an acknowledge when it takes the interrupt. The acknowledge clears only the posted bit of the source whose vector it was given. Because posted bits outlive masking, a request can start in three ways: a fresh event on an enabled source, enabling a source that is already posted, or the global enable rising while something is pending.

All ports are plain control and status pins. There is no data stream here, so there is no valid/ready handshake and no back-pressure. The request and the vector are combinational from registered state and from `gie`, so they follow the global enable within the same cycle.

Top module: `irq_post_ctrl`

## Requirements
- R1: A 1 on `src_evt[i]` at a clock edge sets posted bit i. The bit stays set, whatever the mask, until a clear or a taken acknowledge removes it.
- R2: If an event on source i arrives in the same cycle as a clear of source i (by write or by acknowledge), posted bit i stays set.
- R3: While `cfg_clr_we` is high, each 1 bit of `cfg_clr_wdata` clears the matching posted bit at the clock edge. Bits written as 0 leave their posted bits unchanged.
- R4: While `cfg_mask_we` is high, `cfg_mask_wdata` replaces the whole enable register at the clock edge. A source is pending only when both its posted bit and its enable bit (1 = enabled) are set.
- R5: The lowest pending index wins. `irq_vec` equals VEC_BASE + 4 × index, which gives 0x00 to 0x1C with the defaults. When nothing is pending, `irq_vec` equals VEC_BASE.
- R6: `irq_req` is high exactly when `gie` is 1 and at least one source is pending. It follows `gie` in the same cycle.
- R7: An `irq_ack` while `irq_req` is high clears, at that edge, only the posted bit of the source currently shown on `irq_vec`.
- R8: An `irq_ack` while `irq_req` is low changes no posted bit.
- R9: After reset, all posted bits and all enable bits are 0 and `irq_req` is low.
- R10: Enabling an already-posted source, or raising `gie` while a source is pending, raises `irq_req` with no new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_evt | input | N_SRC | Per-source event pulses |
| gie | input | 1 | CPU global interrupt enable flag |
| cfg_mask_we | input | 1 | Enable register write strobe |
| cfg_mask_wdata | input | N_SRC | New enable register value |
| cfg_clr_we | input | 1 | Posted-clear write strobe |
| cfg_clr_wdata | input | N_SRC | Clear pattern, 1 clears |
| irq_ack | input | 1 | CPU has taken the interrupt |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | VEC_W | Vector of the selected source |

## Verification
The hardest cases to reach are collisions in a single edge. One is an acknowledge arriving while several sources are posted. The other is an event landing in the same cycle as its own clear, whether that clear comes from a write or from an acknowledge. The bench drives these strobes together in one cycle and then checks which bits survive, by reading the vector and the request.

Around those cases, a sweep covers every 8-bit posted pattern against several enable patterns, with `gie` at both values. The expected request and vector are computed arithmetically in the bench.

// File: rtl/irq_post_pkg.sv
package irq_post_pkg;
  function automatic logic [7:0] vec_of(input logic [7:0] base, input int unsigned idx);
    vec_of = base + 8'(idx * 4);
  endfunction
endpackage

// File: rtl/irq_post_bank.sv
module irq_post_bank #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] posted_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        posted_o[i] <= 1'b0;
      else if (evt_i[i]) posted_o[i] <= 1'b1;
      else if (clr_i[i]) posted_o[i] <= 1'b0;
    end

    AST_EVT_POSTS: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[i] |=> posted_o[i]); // R2
    AST_POSTED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (posted_o[i] && !clr_i[i]) |=> posted_o[i]); // R1
    AST_IDLE_STAYS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (!posted_o[i] && !evt_i[i]) |=> !posted_o[i]); // R1
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [N_SRC-1:0] wdata_i,
  output logic [N_SRC-1:0] mask_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_o <= '0;
    else if (we_i) mask_o <= wdata_i;
  end

  AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(mask_o)); // R4
  AST_MASK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (mask_o == $past(wdata_i))); // R4
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] pend_i,
  output logic             any_o,
  output logic [IDX_W-1:0] sel_o
);
  always_comb begin
    sel_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) sel_o = IDX_W'(i);
    end
  end
  assign any_o = |pend_i;

  logic [N_SRC-1:0] below;
  assign below = (N_SRC'(1) << sel_o) - N_SRC'(1);

  AST_SEL_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> pend_i[sel_o]); // R5
  AST_SEL_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> ((pend_i & below) == '0)); // R5
endmodule

// File: rtl/irq_post_ctrl.sv
module irq_post_ctrl
  import irq_post_pkg::*;
#(
  parameter int         N_SRC    = 8,
  parameter int         VEC_W    = 8,
  parameter logic [7:0] VEC_BASE = 8'h00,
  localparam int        IDX_W    = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_evt,
  input  logic             gie,
  input  logic             cfg_mask_we,
  input  logic [N_SRC-1:0] cfg_mask_wdata,
  input  logic             cfg_clr_we,
  input  logic [N_SRC-1:0] cfg_clr_wdata,
  input  logic             irq_ack,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec
);
  logic [N_SRC-1:0] posted, mask, pending, clr_all, ack_clr, wr_clr;
  logic             any_pend;
  logic [IDX_W-1:0] sel;

  assign ack_clr = (irq_ack && irq_req) ? (N_SRC'(1) << sel) : '0;
  assign wr_clr  = cfg_clr_we ? cfg_clr_wdata : '0;
  assign clr_all = ack_clr | wr_clr;

  irq_post_bank #(.N_SRC(N_SRC)) bank_i (
    .clk(clk), .rst_n(rst_n), .evt_i(src_evt), .clr_i(clr_all), .posted_o(posted));

  irq_mask_reg #(.N_SRC(N_SRC)) mask_i (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_mask_we), .wdata_i(cfg_mask_wdata), .mask_o(mask));

  assign pending = posted & mask;

  irq_prio_enc #(.N_SRC(N_SRC)) enc_i (
    .clk(clk), .rst_n(rst_n), .pend_i(pending), .any_o(any_pend), .sel_o(sel));

  assign irq_req = gie & any_pend;
  assign irq_vec = VEC_W'(vec_of(VEC_BASE, int'(sel)));

  AST_ACK_CLEARS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && !src_evt[sel]) |=> !posted[$past(sel)]); // R7
  AST_IDLE_ACK_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !irq_req && !cfg_clr_we) |=>
      (posted == ($past(posted) | $past(src_evt)))); // R8
  AST_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_clr_we && !irq_ack) |=>
      ((posted & $past(cfg_clr_wdata) & ~$past(src_evt)) == '0)); // R3
  AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (gie && (posted & mask) != '0)); // R6
endmodule

// File: tb/irq_post_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_post_ctrl_tb_top;
  localparam int N = 8;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] src_evt = '0, mwd = '0, cwd = '0;
  logic gie = 0, mwe = 0, cwe = 0, ack = 0;
  logic irq_req;
  logic [7:0] irq_vec;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  irq_post_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .gie(gie),
    .cfg_mask_we(mwe), .cfg_mask_wdata(mwd), .cfg_clr_we(cwe), .cfg_clr_wdata(cwd),
    .irq_ack(ack), .irq_req(irq_req), .irq_vec(irq_vec));

  function automatic logic [7:0] exp_vec(input logic [N-1:0] p);
    exp_vec = 8'h00;
    for (int i = N - 1; i >= 0; i--) if (p[i]) exp_vec = 8'(i * 4);
  endfunction

  task automatic chk(input string rq, input logic ar, input logic er,
                     input logic [7:0] av, input logic [7:0] ev);
    n_chk++;
    if (ar !== er || av !== ev) begin
      n_bad++;
      $display("FAIL %s: req=%0b vec=%02h expected req=%0b vec=%02h", rq, ar, av, er, ev);
    end
  endtask

  task automatic tick(input logic [N-1:0] e, input logic ce, input logic [N-1:0] cd,
                      input logic me, input logic [N-1:0] md, input logic a);
    @(negedge clk);
    src_evt = e; cwe = ce; cwd = cd; mwe = me; mwd = md; ack = a;
    @(posedge clk); #1;
    src_evt = '0; cwe = 0; cwd = '0; mwe = 0; mwd = '0; ack = 0;
    #1;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [N-1:0] masks[4];
    repeat (3) @(posedge clk);
    #1; gie = 1; #1;
    chk("R9 reset", irq_req, 1'b0, irq_vec, 8'h00);
    @(negedge clk); rst_n = 1;
    // R9: enable register is zero after reset, so an event alone does not request
    tick(8'h01, 0, '0, 0, '0, 0);
    chk("R9 mask zero", irq_req, 1'b0, irq_vec, 8'h00);
    // R10: enabling an already-posted source raises the request with no new event
    tick('0, 0, '0, 1, 8'hFF, 0);
    chk("R10 unmask posted", irq_req, 1'b1, irq_vec, 8'h00);
    gie = 0; #1;
    chk("R6 gie low", irq_req, 1'b0, irq_vec, 8'h00);
    gie = 1; #1;
    chk("R10 gie rise", irq_req, 1'b1, irq_vec, 8'h00);

    // R3 and R2: clear write on bits 0 and 2 while bit 2 also gets an event
    tick(8'h06, 0, '0, 0, '0, 0);                  // posted = 07
    tick(8'h04, 1, 8'h05, 0, '0, 0);               // posted = 06
    chk("R2/R3 clear vs event", irq_req, 1'b1, irq_vec, 8'h04);
    tick('0, 1, 8'h02, 0, '0, 0);                  // posted = 04
    chk("R3 zero bits kept", irq_req, 1'b1, irq_vec, 8'h08);

    // R7: ack clears only the selected source
    tick(8'h30, 0, '0, 0, '0, 0);                  // posted = 34
    tick('0, 0, '0, 0, '0, 1);                     // drops bit 2
    chk("R7 ack selected", irq_req, 1'b1, irq_vec, 8'h10);
    // R2: ack on bit 4 with an event on bit 4 in the same cycle
    tick(8'h10, 0, '0, 0, '0, 1);
    chk("R2 ack vs event", irq_req, 1'b1, irq_vec, 8'h10);
    // R8: ack while gie low has no effect
    gie = 0;
    tick('0, 0, '0, 0, '0, 1);
    gie = 1; #1;
    chk("R8 ack ignored", irq_req, 1'b1, irq_vec, 8'h10);
    // R1: masked posted bit is retained while masked
    tick('0, 0, '0, 1, 8'h00, 0);
    chk("R4 all masked", irq_req, 1'b0, irq_vec, 8'h00);
    tick('0, 0, '0, 1, 8'h20, 0);
    chk("R1 retained masked", irq_req, 1'b1, irq_vec, 8'h14);

    // R5/R6/R4/R1: sweep all posted patterns against several enable patterns
    for (int p = 0; p < 256; p++) begin
      masks[0] = 8'hFF; masks[1] = 8'h0F; masks[2] = 8'hA5; masks[3] = ~8'(p);
      for (int k = 0; k < 4; k++) begin
        tick('0, 1, 8'hFF, 1, masks[k], 0);
        tick(8'(p), 0, '0, 0, '0, 0);
        gie = 1; #1;
        chk("R5 sweep", irq_req, (8'(p) & masks[k]) != 0, irq_vec, exp_vec(8'(p) & masks[k]));
        gie = 0; #1;
        chk("R6 sweep", irq_req, 1'b0, irq_vec, exp_vec(8'(p) & masks[k]));
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule